// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the software-visible register bank of a FIFO-based serial port. A simple single-cycle bus addresses it by byte offset. It holds the mode, bit-rate, control, port and FIFO-control settings and drives them out to the neighbouring bit-rate generator, shifter and receive FIFO. It also keeps the port's five status flags and raises the transmit and receive interrupt lines.

A write to the transmit-data offset captures the byte and presents it to the transmit shifter with a one-cycle strobe. A read of the receive-data offset pops the external receive FIFO, which reports its occupancy, its next byte and whether its trigger level has been reached. A break indication from the line sets the break flag.

Each status flag is cleared by writing 0 to its bit. Writing 1 leaves it as it is. While the transmitter is enabled, every status read sets the transmit flags again.

Top module: `serRegBank`

## Requirements
- R1: After reset: mode 0x00, bit rate 0xFF, control 0x20, port 0x00, FIFO control 0x0000, both interrupts low, transmit strobe low. The status register reads 0x60, which is transmit-end (bit 6) and transmit-empty (bit 5) set and break, receive-full and data-ready clear.
- R2: Writes are masked as follows: mode (offset 0x00) with 0x7B, control (0x08) with 0xFA, port (0x20) with 0xF3. Bit rate (0x04) is stored unmasked. These values appear on the matching outputs one cycle after the write and read back through the bus. Writes to line status (0x24) change nothing, and it reads as 0.
- R3: The status register (offset 0x10) holds transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. All other bits read 0. A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. In the same cycle, such a clear takes precedence over a hardware set.
- R4: A write to transmit data (0x0C) pulses txStrobe for exactly one cycle in the next cycle, with txByte equal to the low byte written. It also clears transmit-empty.
- R5: A status read while control bit 5 (transmit enable) is 1 sets transmit-end and transmit-empty after the read. The value returned is the one from before the read.
- R6: A control write with bit 5 at 0 sets transmit-end.
- R7: txIrq equals control bit 7 from the cycle after a control write.
- R8: Each cycle, rxTrigHit sets receive-full. rxTrigHit also sets rxIrq when control bit 6 is 1. Data-ready is set in any cycle with rxCount nonzero and rxTrigHit low. rxIrq is cleared by a status write that writes 0 to bit 1 or bit 0, and by a control write with bit 6 at 0.
- R9: A breakIn pulse sets the break flag (status bit 4).
- R10: A read of receive data (0x14) with rxCount nonzero asserts rxPop in the same cycle and returns rxData zero-extended. With rxCount zero it returns 0 and does not pop. A read of 0x1C returns rxCount zero-extended.
- R11: A write to FIFO control (0x18) stores all 16 bits and drives them on fifoCtlOut. When bit 1 is written 1, fifoClr pulses for one cycle.
- R12: busRdata is updated one cycle after a read strobe and holds between reads. Reads of unmapped or misaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| rxData | input | 8 | Head byte of the receive FIFO |
| rxCount | input | 5 | Receive FIFO occupancy |
| rxTrigHit | input | 1 | Receive FIFO at or above its trigger level |
| breakIn | input | 1 | Break detected on the line |
| rxPop | output | 1 | Pop the receive FIFO |
| txStrobe | output | 1 | Transmit byte valid, one cycle |
| txByte | output | 8 | Byte to transmit |
| fifoClr | output | 1 | Receive FIFO clear pulse |
| fifoCtlOut | output | 16 | FIFO control setting |
| modeOut | output | 8 | Mode setting |
| rateOut | output | 8 | Bit-rate setting |
| ctrlOut | output | 8 | Control setting |
| portOut | output | 8 | Port setting |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach is a hardware set event and a software action on the same flag in the same cycle. Examples are a break or trigger pulse during a write that clears that flag, or a transmit-data write during a status read with the transmitter enabled. Directed sequences first walk each flag through set, selective clear and re-arm. A long stretch of pseudo-random bus operations then runs with independently toggling trigger, break and count inputs, so these collisions occur many times. A behavioural model in the bench is compared against every output on every clock.

// File: rtl/serRegPkg.sv
package serRegPkg;
  localparam int ADDR_W = 6;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_RATE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_TXD   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_RXD   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_FCTL  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_RCNT  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_PORT  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_LSTAT = 6'h24;

  localparam logic [REG_W-1:0] MASK_MODE = 8'h7B;
  localparam logic [REG_W-1:0] MASK_CTRL = 8'hFA;
  localparam logic [REG_W-1:0] MASK_PORT = 8'hF3;

  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RDF  = 1;
  localparam int ST_DR   = 0;

  localparam int CT_TXIE = 7;
  localparam int CT_RXIE = 6;
  localparam int CT_TXEN = 5;

  localparam int FC_CLR = 1;

  typedef enum logic [3:0] {
    RS_NONE, RS_MODE, RS_RATE, RS_CTRL, RS_TXD, RS_STAT,
    RS_RXD, RS_FCTL, RS_RCNT, RS_PORT
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrRate;
    logic   wrCtrl;
    logic   wrTxd;
    logic   wrStat;
    logic   wrFctl;
    logic   wrPort;
    logic   rdStat;
    logic   rdAny;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/serRegDecode.sv
module serRegDecode
  import serRegPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [CNT_W-1:0]  rxCount,
  output strobe_t           strb,
  output logic              rxPop
);
  logic [ADDR_W-1:0] wrHit;

  always_comb begin
    strb = '0;
    strb.rdSel = RS_NONE;
    if (busWrEn) begin
      unique case (busAddr)
        OFF_MODE: strb.wrMode = 1'b1;
        OFF_RATE: strb.wrRate = 1'b1;
        OFF_CTRL: strb.wrCtrl = 1'b1;
        OFF_TXD:  strb.wrTxd  = 1'b1;
        OFF_STAT: strb.wrStat = 1'b1;
        OFF_FCTL: strb.wrFctl = 1'b1;
        OFF_PORT: strb.wrPort = 1'b1;
        default:  ;
      endcase
    end
    if (busRdEn) begin
      strb.rdAny = 1'b1;
      unique case (busAddr)
        OFF_MODE: strb.rdSel = RS_MODE;
        OFF_RATE: strb.rdSel = RS_RATE;
        OFF_CTRL: strb.rdSel = RS_CTRL;
        OFF_TXD:  strb.rdSel = RS_TXD;
        OFF_STAT: strb.rdSel = RS_STAT;
        OFF_RXD:  strb.rdSel = RS_RXD;
        OFF_FCTL: strb.rdSel = RS_FCTL;
        OFF_RCNT: strb.rdSel = RS_RCNT;
        OFF_PORT: strb.rdSel = RS_PORT;
        default:  strb.rdSel = RS_NONE;
      endcase
      strb.rdStat = (busAddr == OFF_STAT);
    end
  end

  assign rxPop = busRdEn && (busAddr == OFF_RXD) && (rxCount != '0);

  // R2: line-status writes raise no write strobe at all
  assign wrHit = {strb.wrMode, strb.wrRate, strb.wrCtrl, strb.wrTxd, strb.wrStat, strb.wrFctl};
  always_comb begin
    if (busWrEn && busAddr == OFF_LSTAT)
      a_r2_lstat_ignored: assert (wrHit == '0 && !strb.wrPort);
  end
endmodule

// File: rtl/serRegDatapath.sv
module serRegDatapath
  import serRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [REG_W-1:0]  rxData,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              rxTrigHit,
  input  logic              breakIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              txStrobe,
  output logic [REG_W-1:0]  txByte,
  output logic              fifoClr,
  output logic [DATA_W-1:0] fifoCtlOut,
  output logic [REG_W-1:0]  modeOut,
  output logic [REG_W-1:0]  rateOut,
  output logic [REG_W-1:0]  ctrlOut,
  output logic [REG_W-1:0]  portOut,
  output logic              txIrq,
  output logic              rxIrq
);
  localparam int PAD_B = DATA_W - REG_W;
  localparam int PAD_C = DATA_W - CNT_W;

  logic [REG_W-1:0]  modeQ, rateQ, ctrlQ, portQ, txByteQ;
  logic [DATA_W-1:0] fctlQ, rdVal, rdQ;
  logic              txStbQ, fifoClrQ, rxIrqQ;
  logic              tendQ, tdeQ, brkQ, rdfQ, drQ;
  logic [REG_W-1:0]  statVal;
  logic              rearm;

  assign rearm = strb.rdStat && ctrlQ[CT_TXEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      rateQ    <= 8'hFF;
      ctrlQ    <= 8'h20;
      portQ    <= '0;
      fctlQ    <= '0;
      txByteQ  <= '0;
      txStbQ   <= 1'b0;
      fifoClrQ <= 1'b0;
    end else begin
      txStbQ   <= strb.wrTxd;
      fifoClrQ <= strb.wrFctl && busWdata[FC_CLR];
      if (strb.wrMode) modeQ <= busWdata[REG_W-1:0] & MASK_MODE;
      if (strb.wrRate) rateQ <= busWdata[REG_W-1:0];
      if (strb.wrCtrl) ctrlQ <= busWdata[REG_W-1:0] & MASK_CTRL;
      if (strb.wrPort) portQ <= busWdata[REG_W-1:0] & MASK_PORT;
      if (strb.wrFctl) fctlQ <= busWdata;
      if (strb.wrTxd)  txByteQ <= busWdata[REG_W-1:0];
    end
  end

  // Flags: hardware set first, software clear last so the clear wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tendQ  <= 1'b1;
      tdeQ   <= 1'b1;
      brkQ   <= 1'b0;
      rdfQ   <= 1'b0;
      drQ    <= 1'b0;
      rxIrqQ <= 1'b0;
    end else begin
      if (rearm) begin
        tendQ <= 1'b1;
        tdeQ  <= 1'b1;
      end
      if (strb.wrCtrl && !busWdata[CT_TXEN]) tendQ <= 1'b1;
      if (strb.wrTxd) tdeQ <= 1'b0;
      if (breakIn) brkQ <= 1'b1;
      if (rxTrigHit) begin
        rdfQ <= 1'b1;
        if (ctrlQ[CT_RXIE]) rxIrqQ <= 1'b1;
      end
      if (rxCount != '0 && !rxTrigHit) drQ <= 1'b1;
      if (strb.wrStat) begin
        if (!busWdata[ST_TEND]) tendQ <= 1'b0;
        if (!busWdata[ST_TDE])  tdeQ  <= 1'b0;
        if (!busWdata[ST_BRK])  brkQ  <= 1'b0;
        if (!busWdata[ST_RDF])  rdfQ  <= 1'b0;
        if (!busWdata[ST_DR])   drQ   <= 1'b0;
        if (!busWdata[ST_RDF] || !busWdata[ST_DR]) rxIrqQ <= 1'b0;
      end
      if (strb.wrCtrl && !busWdata[CT_RXIE]) rxIrqQ <= 1'b0;
    end
  end

  always_comb begin
    statVal = '0;
    statVal[ST_TEND] = tendQ;
    statVal[ST_TDE]  = tdeQ;
    statVal[ST_BRK]  = brkQ;
    statVal[ST_RDF]  = rdfQ;
    statVal[ST_DR]   = drQ;
  end

  always_comb begin
    unique case (strb.rdSel)
      RS_MODE: rdVal = {{PAD_B{1'b0}}, modeQ};
      RS_RATE: rdVal = {{PAD_B{1'b0}}, rateQ};
      RS_CTRL: rdVal = {{PAD_B{1'b0}}, ctrlQ};
      RS_TXD:  rdVal = {{PAD_B{1'b0}}, txByteQ};
      RS_STAT: rdVal = {{PAD_B{1'b0}}, statVal};
      RS_RXD:  rdVal = (rxCount != '0) ? {{PAD_B{1'b0}}, rxData} : '0;
      RS_FCTL: rdVal = fctlQ;
      RS_RCNT: rdVal = {{PAD_C{1'b0}}, rxCount};
      RS_PORT: rdVal = {{PAD_B{1'b0}}, portQ};
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (strb.rdAny) rdQ <= rdVal;
  end

  assign busRdata   = rdQ;
  assign txStrobe   = txStbQ;
  assign txByte     = txByteQ;
  assign fifoClr    = fifoClrQ;
  assign fifoCtlOut = fctlQ;
  assign modeOut    = modeQ;
  assign rateOut    = rateQ;
  assign ctrlOut    = ctrlQ;
  assign portOut    = portQ;
  assign txIrq      = ctrlQ[CT_TXIE];
  assign rxIrq      = rxIrqQ;

  a_r4_txd_clears_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTxd |=> !tdeQ);
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |=> !txStrobe || $past(strb.wrTxd));
  a_r5_read_rearms: assert property (@(posedge clk) disable iff (!rstN)
    (rearm && !strb.wrTxd && !strb.wrStat) |=> (tdeQ && tendQ));
  a_r7_txirq_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> (txIrq == $past(busWdata[CT_TXIE])));
  a_r8_ctrl_drops_rxirq: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && !busWdata[CT_RXIE]) |=> !rxIrq);
  a_r3_zero_clears_break: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && !busWdata[ST_BRK]) |=> !brkQ);
  a_r9_break_sets: assert property (@(posedge clk) disable iff (!rstN)
    (breakIn && !(strb.wrStat && !busWdata[ST_BRK])) |=> brkQ);
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdAny && strb.rdSel == RS_NONE) |=> (busRdata == '0));
endmodule

// File: rtl/serRegBank.sv
module serRegBank
  import serRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [7:0]        rxData,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              rxTrigHit,
  input  logic              breakIn,
  output logic              rxPop,
  output logic              txStrobe,
  output logic [7:0]        txByte,
  output logic              fifoClr,
  output logic [DATA_W-1:0] fifoCtlOut,
  output logic [7:0]        modeOut,
  output logic [7:0]        rateOut,
  output logic [7:0]        ctrlOut,
  output logic [7:0]        portOut,
  output logic              txIrq,
  output logic              rxIrq
);
  strobe_t strb;

  serRegDecode #(.CNT_W(CNT_W)) uDecode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .rxCount (rxCount),
    .strb    (strb),
    .rxPop   (rxPop)
  );

  serRegDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .rxData     (rxData),
    .rxCount    (rxCount),
    .rxTrigHit  (rxTrigHit),
    .breakIn    (breakIn),
    .busRdata   (busRdata),
    .txStrobe   (txStrobe),
    .txByte     (txByte),
    .fifoClr    (fifoClr),
    .fifoCtlOut (fifoCtlOut),
    .modeOut    (modeOut),
    .rateOut    (rateOut),
    .ctrlOut    (ctrlOut),
    .portOut    (portOut),
    .txIrq      (txIrq),
    .rxIrq      (rxIrq)
  );
endmodule

// File: tb/serRegBank_test.sv
`timescale 1ns/1ps
module serRegBank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [7:0]  rxData = '0;
  logic [4:0]  rxCount = '0;
  logic        rxTrigHit = 1'b0, breakIn = 1'b0;
  logic        rxPop, txStrobe, fifoClr, txIrq, rxIrq;
  logic [7:0]  txByte, modeOut, rateOut, ctrlOut, portOut;
  logic [15:0] fifoCtlOut;

  always #2 clk = ~clk;

  serRegBank uut (.*);

  int nChk = 0, nFail = 0;
  bit finished = 0;
  string curTag = "R1";

  // behavioural model state
  int mMode, mRate, mCtrl, mPort, mFctl, mTxByte, mRd;
  bit mTend, mTde, mBrk, mRdf, mDr, mRxIrq, mTxStb, mFifoClr;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mRate = 'hFF; mCtrl = 'h20; mPort = 0; mFctl = 0; mTxByte = 0; mRd = 0;
    mTend = 1; mTde = 1; mBrk = 0; mRdf = 0; mDr = 0; mRxIrq = 0; mTxStb = 0; mFifoClr = 0;
  endtask

  function automatic int statNow();
    return (int'(mTend) << 6) | (int'(mTde) << 5) | (int'(mBrk) << 4) | (int'(mRdf) << 1) | int'(mDr);
  endfunction

  task automatic modelStep();
    int w = int'(busWdata);
    int a = int'(busAddr);
    bit wr = busWrEn, rd = busRdEn;
    bit oldTxen = mCtrl[5], oldRxie = mCtrl[6];
    int rv = 0;
    if (rd) begin
      case (a)
        'h00: rv = mMode;   'h04: rv = mRate;  'h08: rv = mCtrl;
        'h0C: rv = mTxByte; 'h10: rv = statNow();
        'h14: rv = (rxCount != 0) ? int'(rxData) : 0;
        'h18: rv = mFctl;   'h1C: rv = int'(rxCount); 'h20: rv = mPort;
        default: rv = 0;
      endcase
      mRd = rv;
    end
    mTxStb = wr && a == 'h0C;
    mFifoClr = wr && a == 'h18 && w[1];
    if (rd && a == 'h10 && oldTxen) begin mTend = 1; mTde = 1; end
    if (wr && a == 'h08 && !w[5]) mTend = 1;
    if (wr && a == 'h0C) begin mTde = 0; mTxByte = w & 'hFF; end
    if (breakIn) mBrk = 1;
    if (rxTrigHit) begin mRdf = 1; if (oldRxie) mRxIrq = 1; end
    if (rxCount != 0 && !rxTrigHit) mDr = 1;
    if (wr && a == 'h10) begin
      if (!w[6]) mTend = 0;
      if (!w[5]) mTde = 0;
      if (!w[4]) mBrk = 0;
      if (!w[1]) mRdf = 0;
      if (!w[0]) mDr = 0;
      if (!w[1] || !w[0]) mRxIrq = 0;
    end
    if (wr && a == 'h08 && !w[6]) mRxIrq = 0;
    if (wr) case (a)
      'h00: mMode = w & 'h7B;
      'h04: mRate = w & 'hFF;
      'h08: mCtrl = w & 'hFA;
      'h18: mFctl = w;
      'h20: mPort = w & 'hF3;
      default: ;
    endcase
  endtask

  task automatic compareAll();
    chk(curTag, int'(busRdata), mRd);
    chk("R4 txStrobe", int'(txStrobe), int'(mTxStb));
    chk("R4 txByte", int'(txByte), mTxByte);
    chk("R7 txIrq", int'(txIrq), int'(mCtrl[7]));
    chk("R8 rxIrq", int'(rxIrq), int'(mRxIrq));
    chk("R11 fifoClr", int'(fifoClr), int'(mFifoClr));
    chk("R11 fifoCtlOut", int'(fifoCtlOut), mFctl);
    chk("R2 modeOut", int'(modeOut), mMode);
    chk("R2 rateOut", int'(rateOut), mRate);
    chk("R2 ctrlOut", int'(ctrlOut), mCtrl);
    chk("R2 portOut", int'(portOut), mPort);
  endtask

  // one bus cycle: drive at negedge, check rxPop, advance, compare
  task automatic tick(bit wr, bit rd, int a, int w);
    busWrEn = wr; busRdEn = rd; busAddr = 6'(a); busWdata = 16'(w);
    #1;
    chk("R10 rxPop", int'(rxPop),
        int'(rd && a == 'h14 && rxCount != 0));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    busWrEn = 0; busRdEn = 0; rxTrigHit = 0; breakIn = 0;
  endtask

  task automatic wrReg(int a, int w); tick(1, 0, a, w); endtask
  task automatic rdReg(int a, int exp);
    tick(0, 1, a, 0);
    chk({curTag, " direct"}, int'(busRdata), exp);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll();
    curTag = "R1";
    rdReg('h00, 'h00); rdReg('h04, 'hFF); rdReg('h08, 'h20);
    rdReg('h20, 'h00); rdReg('h18, 'h00); rdReg('h10, 'h60);

    curTag = "R2";
    wrReg('h00, 'hFF); rdReg('h00, 'h7B);
    wrReg('h20, 'hFF); rdReg('h20, 'hF3);
    wrReg('h04, 'h5A); rdReg('h04, 'h5A);
    wrReg('h24, 'hFF); rdReg('h24, 'h00); rdReg('h00, 'h7B);
    curTag = "R7";
    wrReg('h08, 'hFF); rdReg('h08, 'hFA);
    wrReg('h08, 'h20);

    curTag = "R4";
    wrReg('h0C, 'hA5);
    curTag = "R5";
    rdReg('h10, 'h40); rdReg('h10, 'h60);

    curTag = "R3";
    wrReg('h08, 'h00);
    wrReg('h10, 'h00); rdReg('h10, 'h00);
    wrReg('h10, 'hFF); rdReg('h10, 'h00);
    curTag = "R6";
    wrReg('h08, 'h00); rdReg('h10, 'h40);
    curTag = "R5";
    wrReg('h08, 'h20); wrReg('h10, 'h00);
    rdReg('h10, 'h00); rdReg('h10, 'h60);

    curTag = "R9";
    breakIn = 1; tick(0, 0, 0, 0);
    rdReg('h10, 'h70);
    curTag = "R3";
    wrReg('h10, 'hEF); rdReg('h10, 'h60);
    breakIn = 1; wrReg('h10, 'hEF); rdReg('h10, 'h60);

    curTag = "R8";
    wrReg('h08, 'h60);
    rxTrigHit = 1; tick(0, 0, 0, 0);
    rdReg('h10, 'h62);
    wrReg('h10, 'hFD); rdReg('h10, 'h60);
    rxTrigHit = 1; tick(0, 0, 0, 0);
    wrReg('h08, 'h20);
    rxCount = 3; tick(0, 0, 0, 0); rxCount = 0;
    rdReg('h10, 'h63);
    wrReg('h10, 'hFC); rdReg('h10, 'h60);

    curTag = "R10";
    rxCount = 3; rxData = 'h3C;
    rdReg('h14, 'h3C); rdReg('h1C, 3);
    rxCount = 0; rdReg('h14, 0); rdReg('h1C, 0);

    curTag = "R11";
    wrReg('h18, 'hC2); rdReg('h18, 'hC2);
    wrReg('h18, 'h1240); rdReg('h18, 'h1240);

    curTag = "R12";
    rdReg('h28, 0); rdReg('h02, 0);
    tick(0, 0, 0, 0);

    curTag = "R3 mix";
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 11);
      int adr = (sel == 11) ? 'h09 : sel * 4;
      bit dw = $urandom_range(0, 1);
      rxTrigHit = ($urandom_range(0, 7) == 0);
      breakIn   = ($urandom_range(0, 9) == 0);
      rxCount   = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(1, 16)) : 5'd0;
      rxData    = 8'($urandom);
      tick(dw, !dw, adr, int'(16'($urandom)));
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule